// File: doc/BRIEF.md
# Trace overflow recovery controller

This block sits between the trace packet producers and a small internal packet buffer, and handles the case where the buffer runs out of room. While the buffer reports full, every request from the producers is thrown away. That includes timing packets and packets that mark tracing being enabled or disabled. Once the buffer has room again, the controller first places an overflow marker. It then pulses a reset of the IP and return compression history, so that no later packet refers to one that was lost. If tracing was fully active at the moment of recovery, it follows the marker with a flow-update packet that carries the current IP.

The block keeps a saturating count of the bytes of every packet it actually passes on. It also holds a stopped flag. A trace-stop event sets this flag in any state, including during an overflow. While the flag is set, all requests are blocked until software clears it.

Packet kind encoding on `req_kind` / `out_kind`: 0 timing, 1 branch data, 2 trace-enable, 3 trace-disable, 4 stop, 5 overflow marker, 6 flow-update.

Top module: `trace_ovf_recovery`

## Requirements
- R1: While `buf_full` is 1, no packet appears on the output, and `byte_count` does not change one cycle later. A request that arrives while `buf_full` is 1 in normal operation starts an overflow and is discarded.
- R2: After an overflow, the first packet out is an overflow marker (kind 5, length OVF_LEN, default 2). It is seen two cycles after the first cycle with `buf_full` at 0. Requests in those two cycles are discarded.
- R3: `comp_reset` is 1 for exactly the one cycle in which the overflow marker is on the output, and is 0 at all other times.
- R4: The flow-update packet (kind 6, length FUP_LEN, default 7) is scheduled only if `branch_en` and `packet_en` are both 1 in the first cycle with `buf_full` at 0. It then follows the marker one cycle later, and its IP is `cur_ip` in the cycle in which it is emitted.
- R5: If `packet_en` is 0 at that moment, no flow-update packet is produced. A later trace-enable request (kind 2) passes through as a normal packet with its own IP.
- R6: While a flow-update packet is pending, a timing request (kind 0) is passed on and the flow-update waits. Any other request in that cycle is discarded, and the flow-update is emitted in its place.
- R7: `byte_count` grows by the length of each packet on the output, takes no account of discarded requests, and saturates at 2^CNT_W-1.
- R8: `stop_event` sets `stopped` one cycle later in every state, including during an overflow. `stop_clear` clears it, and `stop_event` wins when both are 1.
- R9: While `stopped` is 1, no packet is output: requests are discarded, and recovery from an overflow emits neither marker nor flow-update.
- R10: In normal operation with room in the buffer, a request appears on the output one cycle later with the same kind, length and IP.
- R11: After reset, `out_valid`, `comp_reset` and `stopped` are 0 and `byte_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A producer requests a packet this cycle |
| req_kind | input | 3 | Packet kind of the request |
| req_len | input | LEN_W | Packet length in bytes |
| req_ip | input | IP_W | IP payload of the request |
| buf_full | input | 1 | Internal packet buffer has no room |
| branch_en | input | 1 | Branch tracing enabled |
| packet_en | input | 1 | Packet generation enabled |
| stop_event | input | 1 | Trace-stop condition hit |
| stop_clear | input | 1 | Software clears the stopped flag |
| cur_ip | input | IP_W | IP of the current instruction |
| out_valid | output | 1 | A packet is generated this cycle |
| out_kind | output | 3 | Kind of the generated packet |
| out_len | output | LEN_W | Length of the generated packet |
| out_ip | output | IP_W | IP payload of the generated packet |
| comp_reset | output | 1 | Flush IP and return compression history |
| byte_count | output | CNT_W | Saturating count of generated bytes |
| stopped | output | 1 | Tracing has been stopped |

## Verification
The bench targets four cases:
- Requests that arrive in the two recovery cycles. A design that let them through would put a packet ahead of the overflow marker.
- The enable state when the buffer clears. Sampling it late, or ignoring `packet_en`, would give a stray flow-update packet, or none at all.
- A timing request and a branch request arriving while the flow-update is pending. Mishandling them would either lose the flow-update or emit two packets in one slot.
- A stop during an overflow, and a counter pushed to its ceiling. A wrong design would leave tracing running after recovery, or wrap the byte count back to a small value.

// File: rtl/trace_ovf_pkg.sv
package trace_ovf_pkg;
  localparam logic [2:0] K_TIMING = 3'd0;
  localparam logic [2:0] K_BRANCH = 3'd1;
  localparam logic [2:0] K_ENABLE = 3'd2;
  localparam logic [2:0] K_DISABLE = 3'd3;
  localparam logic [2:0] K_STOP = 3'd4;
  localparam logic [2:0] K_OVF = 3'd5;
  localparam logic [2:0] K_FUP = 3'd6;

  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_OVERFLOW = 2'd1,
    ST_EMIT_OVF = 2'd2,
    ST_AWAIT_FUP = 2'd3
  } ovf_state_t;
endpackage

// File: rtl/trace_ovf_fsm.sv
module trace_ovf_fsm
  import trace_ovf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_timing,
  input  logic       buf_full,
  input  logic       branch_en,
  input  logic       packet_en,
  input  logic       stopped,
  output logic       acc_req,
  output logic       emit_ovf,
  output logic       emit_fup,
  output logic       req_drop,
  output ovf_state_t state_o
);
  ovf_state_t st_q, st_d;
  logic       fup_due_q;
  logic       clear_now;

  // the cycle in which the buffer regains room; the enables are sampled here
  assign clear_now = (st_q == ST_OVERFLOW) && !buf_full;

  always_comb begin
    st_d     = st_q;
    acc_req  = 1'b0;
    emit_ovf = 1'b0;
    emit_fup = 1'b0;
    req_drop = 1'b0;
    unique case (st_q)
      ST_NORMAL: begin
        if (req_valid) begin
          if (stopped) begin
            req_drop = 1'b1;
          end else if (buf_full) begin
            req_drop = 1'b1;
            st_d     = ST_OVERFLOW;
          end else begin
            acc_req = 1'b1;
          end
        end
      end
      ST_OVERFLOW: begin
        req_drop = req_valid;
        if (!buf_full) st_d = ST_EMIT_OVF;
      end
      ST_EMIT_OVF: begin
        req_drop = req_valid;
        if (stopped) begin
          st_d = ST_NORMAL;
        end else if (!buf_full) begin
          emit_ovf = 1'b1;
          st_d     = fup_due_q ? ST_AWAIT_FUP : ST_NORMAL;
        end
      end
      ST_AWAIT_FUP: begin
        if (stopped) begin
          req_drop = req_valid;
          st_d     = ST_NORMAL;
        end else if (buf_full) begin
          req_drop = req_valid;
          if (req_valid) st_d = ST_OVERFLOW;
        end else if (req_valid && req_timing) begin
          acc_req = 1'b1;
        end else begin
          req_drop = req_valid;
          emit_fup = 1'b1;
          st_d     = ST_NORMAL;
        end
      end
      default: st_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_NORMAL;
      fup_due_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (clear_now) fup_due_q <= branch_en && packet_en;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/trace_byte_ctr.sv
module trace_byte_ctr #(
  parameter int CNT_W = 32,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic [LEN_W-1:0] inc_len,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [LEN_W-1:0] b);
    logic [CNT_W:0] sum;
    sum = {1'b0, a} + (CNT_W + 1)'(b);
    return sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (inc_en) count <= sat_add(count, inc_len);
  end
endmodule

// File: rtl/trace_stop_flag.sv
module trace_stop_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_event,
  input  logic stop_clear,
  output logic stopped
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stopped <= 1'b0;
    else if (stop_event) stopped <= 1'b1;
    else if (stop_clear) stopped <= 1'b0;
  end
endmodule

// File: rtl/trace_ovf_recovery.sv
module trace_ovf_recovery
  import trace_ovf_pkg::*;
#(
  parameter int IP_W = 48,
  parameter int LEN_W = 4,
  parameter int CNT_W = 32,
  parameter int OVF_LEN = 2,
  parameter int FUP_LEN = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_kind,
  input  logic [LEN_W-1:0] req_len,
  input  logic [IP_W-1:0]  req_ip,
  input  logic             buf_full,
  input  logic             branch_en,
  input  logic             packet_en,
  input  logic             stop_event,
  input  logic             stop_clear,
  input  logic [IP_W-1:0]  cur_ip,
  output logic             out_valid,
  output logic [2:0]       out_kind,
  output logic [LEN_W-1:0] out_len,
  output logic [IP_W-1:0]  out_ip,
  output logic             comp_reset,
  output logic [CNT_W-1:0] byte_count,
  output logic             stopped
);
  localparam logic [LEN_W-1:0] OVF_L = LEN_W'(OVF_LEN);
  localparam logic [LEN_W-1:0] FUP_L = LEN_W'(FUP_LEN);

  logic             acc_req, emit_ovf, emit_fup, req_drop;
  logic             gen_pkt;
  logic [LEN_W-1:0] gen_len;
  logic [2:0]       gen_kind;
  logic [IP_W-1:0]  gen_ip;
  ovf_state_t       fsm_state;

  trace_stop_flag u_stop (
    .clk(clk), .rst_n(rst_n), .stop_event(stop_event),
    .stop_clear(stop_clear), .stopped(stopped)
  );

  trace_ovf_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_timing(req_kind == K_TIMING), .buf_full(buf_full),
    .branch_en(branch_en), .packet_en(packet_en), .stopped(stopped),
    .acc_req(acc_req), .emit_ovf(emit_ovf), .emit_fup(emit_fup),
    .req_drop(req_drop), .state_o(fsm_state)
  );

  assign gen_pkt = acc_req || emit_ovf || emit_fup;

  always_comb begin
    gen_kind = req_kind;
    gen_len  = req_len;
    gen_ip   = req_ip;
    if (emit_ovf) begin
      gen_kind = K_OVF;
      gen_len  = OVF_L;
      gen_ip   = '0;
    end else if (emit_fup) begin
      gen_kind = K_FUP;
      gen_len  = FUP_L;
      gen_ip   = cur_ip;
    end
  end

  trace_byte_ctr #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .inc_en(gen_pkt), .inc_len(gen_len),
    .count(byte_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_kind   <= '0;
      out_len    <= '0;
      out_ip     <= '0;
      comp_reset <= 1'b0;
    end else begin
      out_valid  <= gen_pkt;
      comp_reset <= emit_ovf;
      if (gen_pkt) begin
        out_kind <= gen_kind;
        out_len  <= gen_len;
        out_ip   <= gen_ip;
      end
    end
  end
endmodule

// File: rtl/trace_ovf_checker.sv
module trace_ovf_checker
  import trace_ovf_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             buf_full,
  input logic             stop_event,
  input logic             out_valid,
  input logic [2:0]       out_kind,
  input logic             comp_reset,
  input logic [CNT_W-1:0] byte_count,
  input logic             stopped,
  input logic             req_drop,
  input ovf_state_t       fsm_state
);
  AST_NO_OUT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |=> !out_valid); // R1
  AST_MARKER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_EMIT_OVF) |=> (!out_valid || out_kind == K_OVF)); // R2
  AST_FLUSH_WITH_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
    comp_reset |-> (out_valid && out_kind == K_OVF)); // R3
  AST_MARKER_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == K_OVF) |-> comp_reset); // R3
  AST_COUNT_ONLY_ON_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(byte_count) |-> out_valid); // R7
  AST_DROP_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_drop && fsm_state == ST_OVERFLOW) |=> !out_valid); // R1
  AST_STOP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_event |=> stopped); // R8
  AST_STOP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |=> !out_valid); // R9
endmodule

bind trace_ovf_recovery trace_ovf_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .buf_full(buf_full), .stop_event(stop_event),
  .out_valid(out_valid), .out_kind(out_kind), .comp_reset(comp_reset),
  .byte_count(byte_count), .stopped(stopped), .req_drop(req_drop),
  .fsm_state(fsm_state)
);

// File: tb/sim_trace_ovf_recovery.sv
`timescale 1ns/1ps
module sim_trace_ovf_recovery;
  localparam int IP_W = 48;
  localparam int LEN_W = 4;
  localparam int CNT_W = 10;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, buf_full = 0, branch_en = 1, packet_en = 1;
  logic stop_event = 0, stop_clear = 0;
  logic [2:0] req_kind = 0;
  logic [LEN_W-1:0] req_len = 0;
  logic [IP_W-1:0] req_ip = 0, cur_ip = 0;
  logic out_valid, comp_reset, stopped;
  logic [2:0] out_kind;
  logic [LEN_W-1:0] out_len;
  logic [IP_W-1:0] out_ip;
  logic [CNT_W-1:0] byte_count;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  trace_ovf_recovery #(.IP_W(IP_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_len(req_len), .req_ip(req_ip), .buf_full(buf_full),
    .branch_en(branch_en), .packet_en(packet_en), .stop_event(stop_event),
    .stop_clear(stop_clear), .cur_ip(cur_ip), .out_valid(out_valid),
    .out_kind(out_kind), .out_len(out_len), .out_ip(out_ip),
    .comp_reset(comp_reset), .byte_count(byte_count), .stopped(stopped)
  );

  // kind[54:52] len[51:48] ip[47:0]
  localparam logic [54:0] VECS [0:5] = '{
    {3'd1, 4'd3, 48'h0000_1000_0010},
    {3'd0, 4'd1, 48'h0000_0000_0000},
    {3'd2, 4'd7, 48'hFFFF_0000_ABCD},
    {3'd3, 4'd7, 48'h0000_2222_3333},
    {3'd1, 4'd15, 48'h8000_0000_0001},
    {3'd0, 4'd2, 48'h0000_0000_0042}
  };

  function automatic int exp_add(input int c, input int l);
    return (c + l > CMAX) ? CMAX : c + l;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic put(input logic v, input logic [2:0] k, input int l, input logic [IP_W-1:0] ip);
    req_valid = v;
    req_kind = k;
    req_len = LEN_W'(l);
    req_ip = ip;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R11 out_valid", 64'(out_valid), 0);
    chk("R11 byte_count", 64'(byte_count), 0);
    chk("R11 stopped", 64'(stopped), 0);
    chk("R11 comp_reset", 64'(comp_reset), 0);
    tick; tick;
    rst_n = 1'b1;
    tick;

    // R10 pass-through table
    for (int i = 0; i < 6; i++) begin
      put(1, VECS[i][54:52], int'(VECS[i][51:48]), VECS[i][47:0]);
      tick;
      exp_cnt = exp_add(exp_cnt, int'(VECS[i][51:48]));
      chk("R10 valid", 64'(out_valid), 1);
      chk("R10 kind", 64'(out_kind), 64'(VECS[i][54:52]));
      chk("R10 len", 64'(out_len), 64'(VECS[i][51:48]));
      chk("R10 ip", 64'(out_ip), 64'(VECS[i][47:0]));
      chk("R7 count", 64'(byte_count), 64'(exp_cnt));
    end
    put(0, 0, 0, 0);
    tick;
    chk("R10 idle", 64'(out_valid), 0);

    // full without a request does not start an overflow
    buf_full = 1; tick;
    buf_full = 0; put(1, 3'd1, 4, 48'h77); tick;
    exp_cnt = exp_add(exp_cnt, 4);
    chk("R1 full no req passes later", 64'(out_kind), 1);
    chk("R7 count", 64'(byte_count), 64'(exp_cnt));

    // overflow with FUP recovery
    buf_full = 1; put(1, 3'd0, 1, 0); tick;
    chk("R1 timing dropped", 64'(out_valid), 0);
    put(1, 3'd2, 7, 48'h55); tick;
    chk("R1 enable pkt dropped", 64'(out_valid), 0);
    chk("R1 count held", 64'(byte_count), 64'(exp_cnt));
    put(0, 0, 0, 0); buf_full = 0; branch_en = 1; packet_en = 1; tick;
    chk("R2 nothing in clear cycle", 64'(out_valid), 0);
    put(1, 3'd0, 1, 0); cur_ip = 48'h1234; tick;
    exp_cnt = exp_add(exp_cnt, 2);
    chk("R2 marker first", 64'(out_kind), 5);
    chk("R2 marker len", 64'(out_len), 2);
    chk("R3 flush pulse", 64'(comp_reset), 1);
    chk("R7 count marker", 64'(byte_count), 64'(exp_cnt));
    put(0, 0, 0, 0); cur_ip = 48'hBEEF_0042; tick;
    exp_cnt = exp_add(exp_cnt, 7);
    chk("R4 fup valid", 64'(out_valid), 1);
    chk("R4 fup kind", 64'(out_kind), 6);
    chk("R4 fup ip", 64'(out_ip), 64'h0000_BEEF_0042);
    chk("R3 pulse ends", 64'(comp_reset), 0);
    chk("R7 count fup", 64'(byte_count), 64'(exp_cnt));
    tick;
    chk("R4 single fup", 64'(out_valid), 0);

    // timing packet while FUP pending
    buf_full = 1; put(1, 3'd1, 3, 1); tick;
    put(0, 0, 0, 0); buf_full = 0; tick;
    tick;
    exp_cnt = exp_add(exp_cnt, 2);
    chk("R2 marker", 64'(out_kind), 5);
    put(1, 3'd0, 1, 48'h9); tick;
    exp_cnt = exp_add(exp_cnt, 1);
    chk("R6 timing passes", 64'(out_kind), 0);
    chk("R7 count timing", 64'(byte_count), 64'(exp_cnt));
    put(1, 3'd1, 5, 48'h3); cur_ip = 48'h600; tick;
    exp_cnt = exp_add(exp_cnt, 7);
    chk("R6 fup replaces branch", 64'(out_kind), 6);
    chk("R6 fup ip", 64'(out_ip), 64'h600);
    chk("R6 branch dropped count", 64'(byte_count), 64'(exp_cnt));
    put(0, 0, 0, 0); tick;
    chk("R6 nothing after", 64'(out_valid), 0);

    // packet_en low at clear: no FUP
    buf_full = 1; put(1, 3'd1, 3, 1); tick;
    put(0, 0, 0, 0); buf_full = 0; packet_en = 0; tick;
    packet_en = 1; tick;
    exp_cnt = exp_add(exp_cnt, 2);
    chk("R2 marker", 64'(out_kind), 5);
    tick;
    chk("R5 no fup", 64'(out_valid), 0);
    put(1, 3'd2, 7, 48'hABC); tick;
    exp_cnt = exp_add(exp_cnt, 7);
    chk("R5 enable pkt", 64'(out_kind), 2);
    chk("R5 enable ip", 64'(out_ip), 64'hABC);
    put(0, 0, 0, 0); tick;

    // stop during overflow
    buf_full = 1; put(1, 3'd1, 3, 1); tick;
    put(0, 0, 0, 0); stop_event = 1; tick;
    stop_event = 0;
    chk("R8 stop in overflow", 64'(stopped), 1);
    buf_full = 0; tick; tick; tick;
    chk("R9 no marker when stopped", 64'(out_valid), 0);
    chk("R9 count held", 64'(byte_count), 64'(exp_cnt));
    put(1, 3'd1, 3, 5); tick;
    chk("R9 request blocked", 64'(out_valid), 0);
    put(0, 0, 0, 0); stop_clear = 1; stop_event = 1; tick;
    chk("R8 event wins", 64'(stopped), 1);
    stop_event = 0; tick;
    stop_clear = 0;
    chk("R8 cleared", 64'(stopped), 0);
    put(1, 3'd1, 3, 5); tick;
    exp_cnt = exp_add(exp_cnt, 3);
    chk("R10 passes after clear", 64'(out_valid), 1);

    // saturation
    put(1, 3'd1, 15, 0);
    for (int i = 0; i < 80; i++) begin
      tick;
      exp_cnt = exp_add(exp_cnt, 15);
    end
    chk("R7 saturated", 64'(byte_count), 64'(CMAX));
    chk("R7 model", 64'(byte_count), 64'(exp_cnt));
    put(0, 0, 0, 0); tick;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule